// File: doc/BRIEF.md
# Configuration Power-Up Initialization Sequencer

This block takes a programmable device from reset, or from a program request, to the moment when configuration loading may begin. It has three inputs from outside: an active-low program request, the sampled level of a shared open-drain init line, and a set of mode-select inputs. It drives the init line low through a drive-enable output, requests configuration-memory clear passes from an external clear engine through a start/done handshake, and raises a one-cycle start pulse when loading may proceed.

While the program request is held low, clear passes run one after another. Once the request is released, one further full clear pass runs. The sequencer then stops driving init and waits as long as any other party holds the line low. When init is seen high, the mode inputs are latched. A master then waits a settling time computed from the clock frequency and a microsecond parameter before starting. A slave starts at once.

Top module: `cfg_powerup_seq`

## Requirements
- R1: While reset is asserted, `clr_start_o` and `cfg_start_o` are low, `mode_o` is zero and `init_drive_low_o` is high. The first clock after reset is released opens a clear pass, and `clr_start_o` is high for exactly one cycle.
- R2: While `prog_n_i` is low, every completed clear pass (`clr_done_i` high) is followed by a new `clr_start_o` pulse, so passes repeat back to back.
- R3: A clear pass during which the synchronised program request was low at any point is followed by exactly one more clear pass once the request is high. Only after that pass completes does the sequencer release init.
- R4: `init_drive_low_o` is high in any cycle in which `prog_n_i` is low, with no clock delay.
- R5: `init_drive_low_o` is high from the `clr_start_o` cycle through the cycle in which `clr_done_i` ends the final pass, and low after that.
- R6: While the init line reads low after clearing has finished, `cfg_start_o` stays low and the sequencer waits without limit.
- R7: In the cycle the synchronised init input is first seen high, `mode_i` is latched into `mode_o`. `mode_o` keeps that value through the start pulse and after it.
- R8: A latched mode with bit 0 equal to 0 means master. When init is released (raw input rises), `cfg_start_o` rises 3 + WAIT_CYC clock edges later, where WAIT_CYC = (CLK_HZ / 1,000,000) * WAIT_US.
- R9: A latched mode with bit 0 equal to 1 means slave. `cfg_start_o` rises 3 clock edges after the raw init input rises.
- R10: `cfg_start_o` is high for exactly one cycle per sequence.
- R11: A low on `prog_n_i` after the start pulse restarts the sequence with new clear passes, and a later release leads to a new start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_n_i | input | 1 | Asynchronous active-low program request |
| init_i | input | 1 | Sampled level of the open-drain init line |
| init_drive_low_o | output | 1 | High enables the pull-down on the init line |
| mode_i | input | MODE_W | Mode-select inputs |
| clr_start_o | output | 1 | One-cycle request to the clear engine to begin a pass |
| clr_done_i | input | 1 | Clear engine signals that the current pass has ended |
| cfg_start_o | output | 1 | One-cycle pulse: configuration may begin |
| mode_o | output | MODE_W | Mode latched when init was released |

## Verification
The bench builds the block with CLK_HZ = 2,000,000 and WAIT_US = 6. This makes the master wait 12 cycles instead of the default 12,500. As a result, exact master and slave start latencies can be checked side by side for several mode codes within a short run. The bench clear engine answers each start after 4 cycles. This is long enough that a program release inside a pass lands while that pass is still running, which exercises the extra-pass rule.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        SQ_RESET,
        SQ_CLR_ISSUE,
        SQ_CLR_BUSY,
        SQ_WAIT_INIT,
        SQ_MASTER_WAIT,
        SQ_LAUNCH,
        SQ_CONFIG
    } seq_state_e;

    // Settling cycles for a given clock rate and wait time, never below one.
    function automatic int unsigned settle_cycles(input int unsigned clk_hz,
                                                  input int unsigned wait_us);
        int unsigned c;
        c = (clk_hz / 1_000_000) * wait_us;
        return (c == 0) ? 1 : c;
    endfunction

    // Mode bit 0 low selects the master role.
    function automatic logic mode_is_master(input logic mode_lsb);
        return ~mode_lsb;
    endfunction

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= RESET_VAL;
            stage2_q <= RESET_VAL;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/cfg_delay_timer.sv
module cfg_delay_timer #(
    parameter int unsigned CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_powerup_seq.sv
module cfg_powerup_seq
    import cfg_seq_pkg::*;
#(
    parameter int unsigned MODE_W  = 3,
    parameter int unsigned CLK_HZ  = 50_000_000,
    parameter int unsigned WAIT_US = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_n_i,
    input  logic              init_i,
    output logic              init_drive_low_o,
    input  logic [MODE_W-1:0] mode_i,
    output logic              clr_start_o,
    input  logic              clr_done_i,
    output logic              cfg_start_o,
    output logic [MODE_W-1:0] mode_o
);
    localparam int unsigned WAIT_CYC = settle_cycles(CLK_HZ, WAIT_US);

    seq_state_e        state_q, state_d;
    logic              dirty_q, dirty_d;
    logic [MODE_W-1:0] mode_q;
    logic              prog_s;
    logic              init_s;
    logic              capture;
    logic              timer_load;
    logic              timer_expired;

    cfg_sync2 #(.RESET_VAL(1'b1)) u_prog_sync (
        .clk (clk),
        .rst (rst),
        .d_i (prog_n_i),
        .q_o (prog_s)
    );

    cfg_sync2 #(.RESET_VAL(1'b0)) u_init_sync (
        .clk (clk),
        .rst (rst),
        .d_i (init_i),
        .q_o (init_s)
    );

    cfg_delay_timer #(.CYCLES(WAIT_CYC)) u_settle (
        .clk       (clk),
        .rst       (rst),
        .load_i    (timer_load),
        .expired_o (timer_expired)
    );

    always_comb begin
        state_d = state_q;
        dirty_d = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            SQ_RESET: state_d = SQ_CLR_ISSUE;
            SQ_CLR_ISSUE: begin
                dirty_d = ~prog_s;
                state_d = SQ_CLR_BUSY;
            end
            SQ_CLR_BUSY: begin
                dirty_d = dirty_q | ~prog_s;
                if (clr_done_i) begin
                    state_d = (!prog_s || dirty_q) ? SQ_CLR_ISSUE : SQ_WAIT_INIT;
                end
            end
            SQ_WAIT_INIT: begin
                if (!prog_s) begin
                    state_d = SQ_CLR_ISSUE;
                end else if (init_s) begin
                    capture = 1'b1;
                    state_d = mode_is_master(mode_i[0]) ? SQ_MASTER_WAIT : SQ_LAUNCH;
                end
            end
            SQ_MASTER_WAIT: begin
                if (!prog_s)            state_d = SQ_CLR_ISSUE;
                else if (timer_expired) state_d = SQ_LAUNCH;
            end
            SQ_LAUNCH: state_d = prog_s ? SQ_CONFIG : SQ_CLR_ISSUE;
            SQ_CONFIG: if (!prog_s) state_d = SQ_CLR_ISSUE;
            default:   state_d = SQ_RESET;
        endcase
    end

    assign timer_load = capture && mode_is_master(mode_i[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_RESET;
            dirty_q <= 1'b0;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            dirty_q <= dirty_d;
            if (capture) mode_q <= mode_i;
        end
    end

    assign clr_start_o      = (state_q == SQ_CLR_ISSUE);
    assign cfg_start_o      = (state_q == SQ_LAUNCH);
    assign mode_o           = mode_q;
    assign init_drive_low_o = (state_q == SQ_RESET) || (state_q == SQ_CLR_ISSUE)
                            || (state_q == SQ_CLR_BUSY) || !prog_n_i;
endmodule

// File: rtl/cfg_powerup_seq_chk.sv
module cfg_powerup_seq_chk
    import cfg_seq_pkg::*;
#(
    parameter int unsigned MODE_W   = 3,
    parameter int unsigned WAIT_CYC = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              prog_n_i,
    input logic              init_drive_low_o,
    input logic              clr_start_o,
    input logic              cfg_start_o,
    input logic [MODE_W-1:0] mode_o,
    input logic              init_s,
    input seq_state_e        state_q
);
    localparam int unsigned CW = $clog2(WAIT_CYC + 2);

    logic [CW-1:0] mw_cnt;
    logic          prev_mw;

    always_ff @(posedge clk) begin
        if (rst) begin
            mw_cnt  <= '0;
            prev_mw <= 1'b0;
        end else begin
            mw_cnt  <= (state_q == SQ_MASTER_WAIT) ? mw_cnt + 1'b1 : '0;
            prev_mw <= (state_q == SQ_MASTER_WAIT);
        end
    end

    p_prog_forces_init_r4: assert property (@(posedge clk) disable iff (rst)
        !prog_n_i |-> init_drive_low_o);

    p_pass_drives_init_r5: assert property (@(posedge clk) disable iff (rst)
        clr_start_o |=> init_drive_low_o);

    p_clr_single_r1: assert property (@(posedge clk) disable iff (rst)
        clr_start_o |=> !clr_start_o);

    p_start_single_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_start_o |=> !cfg_start_o);

    p_mode_kept_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_start_o |=> $stable(mode_o));

    p_wait_held_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_WAIT_INIT && !init_s) |=> !cfg_start_o);

    p_master_span_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_start_o && prev_mw) |-> (mw_cnt == CW'(WAIT_CYC)));
endmodule

bind cfg_powerup_seq cfg_powerup_seq_chk #(
    .MODE_W   (MODE_W),
    .WAIT_CYC (WAIT_CYC)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .prog_n_i         (prog_n_i),
    .init_drive_low_o (init_drive_low_o),
    .clr_start_o      (clr_start_o),
    .cfg_start_o      (cfg_start_o),
    .mode_o           (mode_o),
    .init_s           (init_s),
    .state_q          (state_q)
);

// File: tb/cfg_powerup_seq_tb.sv
module cfg_powerup_seq_tb_top;
    localparam time         CLK_PERIOD = 10ns;
    localparam int unsigned MODE_W     = 3;
    localparam int unsigned CLK_HZ     = 2_000_000;
    localparam int unsigned WAIT_US    = 6;
    localparam int          W          = (CLK_HZ / 1_000_000) * WAIT_US;
    localparam int          CLR_LAT    = 4;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              master;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{mode: 3'b000, master: 1'b1},
        '{mode: 3'b001, master: 1'b0},
        '{mode: 3'b110, master: 1'b1},
        '{mode: 3'b111, master: 1'b0},
        '{mode: 3'b101, master: 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              prog_n = 1'b1;
    logic              ext_hold = 1'b1;
    logic [MODE_W-1:0] mode_in = '0;
    logic              clr_done = 1'b0;
    logic              init_drive_low, clr_start, cfg_start;
    logic [MODE_W-1:0] mode_out;
    logic              init_line;
    int                eng_cnt = 0;
    int                pass_cnt = 0;
    int                checks = 0;
    int                fails = 0;
    bit                done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign init_line = ~(init_drive_low | ext_hold);

    cfg_powerup_seq #(.MODE_W(MODE_W), .CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US)) dut_i (
        .clk              (clk),
        .rst              (rst),
        .prog_n_i         (prog_n),
        .init_i           (init_line),
        .init_drive_low_o (init_drive_low),
        .mode_i           (mode_in),
        .clr_start_o      (clr_start),
        .clr_done_i       (clr_done),
        .cfg_start_o      (cfg_start),
        .mode_o           (mode_out)
    );

    // Clear engine model, reacting on the falling edge.
    always @(negedge clk) begin
        clr_done <= 1'b0;
        if (clr_start) begin
            eng_cnt  <= CLR_LAT;
            pass_cnt <= pass_cnt + 1;
        end else if (eng_cnt != 0) begin
            eng_cnt <= eng_cnt - 1;
            if (eng_cnt == 1) clr_done <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!clr_start && !cfg_start && mode_out == '0 && init_drive_low,
              "R1 reset state", {clr_start, cfg_start, init_drive_low}, 3'b001);
        rst = 1'b0;
        @(negedge clk);
        check(clr_start == 1'b1, "R1 pass after reset", clr_start, 1);
        check(init_drive_low == 1'b1, "R5 drive low at pass start", init_drive_low, 1);
        @(negedge clk);
        check(clr_start == 1'b0, "R1 single start pulse", clr_start, 0);
    endtask

    task automatic wait_release(input string req, output int n);
        n = 0;
        while (init_drive_low && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(!init_drive_low, req, init_drive_low, 0);
    endtask

    task automatic measure_start(output int lat);
        lat = 0;
        ext_hold = 1'b0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cfg_start && lat < 200);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        int lat;
        int base;
        bit held_ok;

        // Table walk: master and slave latencies and mode capture.
        foreach (VECS[i]) begin
            mode_in  = VECS[i].mode;
            ext_hold = 1'b1;
            do_reset();
            wait_release("R5 init released after pass", n);
            check(n >= CLR_LAT - 1 && n <= CLR_LAT + 2, "R5 pass length", n, CLR_LAT);
            repeat (8) @(negedge clk);
            check(!cfg_start, "R6 no start while init held", cfg_start, 0);
            measure_start(lat);
            if (VECS[i].master)
                check(lat == 3 + W, "R8 master latency", lat, 3 + W);
            else
                check(lat == 3, "R9 slave latency", lat, 3);
            check(mode_out == VECS[i].mode, "R7 mode latched", mode_out, VECS[i].mode);
            mode_in = ~VECS[i].mode;
            @(negedge clk);
            check(!cfg_start, "R10 start one cycle", cfg_start, 0);
            repeat (5) @(negedge clk);
            check(mode_out == VECS[i].mode, "R7 mode held", mode_out, VECS[i].mode);
        end

        // Program held low: repeated passes, forced init, extra pass.
        mode_in  = 3'b001;
        ext_hold = 1'b1;
        do_reset();
        wait_release("R5 release before program", n);
        prog_n = 1'b0;
        #1;
        check(init_drive_low, "R4 program forces init low", init_drive_low, 1);
        base = pass_cnt;
        held_ok = 1;
        repeat (40) begin
            @(negedge clk);
            if (!init_drive_low) held_ok = 0;
        end
        check(held_ok, "R4 init low throughout program", held_ok, 1);
        check(pass_cnt - base >= 4, "R2 repeated passes", pass_cnt - base, 4);
        while (!clr_start) @(negedge clk);
        base = pass_cnt;
        prog_n = 1'b1;
        wait_release("R3 release after extra pass", n);
        repeat (10) @(negedge clk);
        check(pass_cnt - base == 2, "R3 one extra pass", pass_cnt - base, 2);
        check(!cfg_start, "R6 waiting after extra pass", cfg_start, 0);
        measure_start(lat);
        check(lat == 3, "R9 slave latency after program", lat, 3);

        // Restart from the configured state.
        repeat (3) @(negedge clk);
        mode_in = 3'b000;
        base = pass_cnt;
        prog_n = 1'b0;
        repeat (12) @(negedge clk);
        check(pass_cnt - base >= 2, "R11 restart clears", pass_cnt - base, 2);
        check(init_drive_low, "R4 init low on restart", init_drive_low, 1);
        prog_n = 1'b1;
        ext_hold = 1'b0;
        n = 0;
        while (!cfg_start && n < 300) begin
            @(negedge clk);
            n++;
        end
        check(cfg_start, "R11 new start after restart", cfg_start, 1);
        check(mode_out == 3'b000, "R11 new mode latched", mode_out, 0);

        finish_run();
    end
endmodule